// File: doc/BRIEF.md
# Compression Benefit Classifier and Predictor

This block decides whether a compressed cache should store newly filled lines in compressed or plain form. For each cache access it receives the replacement-stack position of the matching tag, whether the data for that tag is actually held, whether the line is stored compressed, and the running total of compressed line sizes (in segments) from the top of the stack down to that position. From these it works out what the same access would have done in a cache of half the tags that never compresses. It then sorts the access into one of five outcome classes.

Each class weighs the access. If compression turned a miss into a hit, or would have done so, a benefit equal to the memory latency is added to one global saturating counter. If a hit had to pay for decompression, a cost equal to the decompression latency is subtracted. Other outcomes leave the counter alone. A two-state allocation machine follows the sign of the counter: state ALLOC_PACKED (counter at zero or above) tells the fill path to store lines compressed, and state ALLOC_PLAIN (counter negative) tells it to store them plain. Transition TO_PLAIN is taken when an update makes the counter negative. Transition TO_PACKED is taken when an update brings it back to zero or above. Both latencies are inputs. A normalised mode fixes the cost at 1 and scales the benefit by the latency ratio.

Top module: `cbp_predictor`

## Requirements
- R1: After reset the counter reads 0, `alloc_compressed` is 1 (state ALLOC_PACKED) and `cls_valid` is 0.
- R2: An access with `acc_resident`=1, `acc_depth` 1 or 2 and `acc_compressed`=0 is an unpenalised hit (class code 1) and leaves the counter unchanged. `acc_depth`=0 means no tag matched.
- R3: An access with `acc_resident`=1, `acc_depth` 1 or 2 and `acc_compressed`=1 is a penalised hit (code 2) and subtracts `dec_lat` from the counter.
- R4: An access with `acc_resident`=1 and `acc_depth` 3 or 4 is an avoided miss (code 3) and adds `mem_lat` to the counter.
- R5: An access with `acc_resident`=0, `acc_depth` 1 to 4 and `acc_seg_sum` of at most 16 is an avoidable miss (code 4) and adds `mem_lat` to the counter.
- R6: An access with `acc_depth`=0, or with `acc_resident`=0 and `acc_seg_sum` above 16, is an unavoidable miss (code 5) and leaves the counter unchanged.
- R7: The counter is 19-bit two's complement. Updates clamp at +262143 and at -262144 and never wrap.
- R8: After every update `alloc_compressed` is 1 when the counter is at least zero and 0 when it is negative.
- R9: With `norm_en`=1 a penalised hit subtracts 1, and a benefit adds floor(`mem_lat`/`dec_lat`), or `mem_lat` when `dec_lat` is 0.
- R10: `cls_valid` and `cls_code` show the class of an access at the first rising edge after it is presented with `acc_valid`=1. The counter also changes at that edge. Without an access, `cls_valid` is 0 and the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_resident | input | 1 | Data for the matching tag is held |
| acc_compressed | input | 1 | Matching line is stored compressed |
| acc_depth | input | 3 | Stack position of matching tag, 0 = none |
| acc_seg_sum | input | 6 | Segments summed down to that position |
| mem_lat | input | 16 | Memory latency weight |
| dec_lat | input | 16 | Decompression latency weight |
| norm_en | input | 1 | Normalised weighting mode |
| cls_valid | output | 1 | Class output valid |
| cls_code | output | 3 | Outcome class code |
| pred_value | output | 19 | Signed counter value |
| alloc_compressed | output | 1 | Store next fill compressed |

## Verification
Every combination of residency, compression flag, stack depth 0 to 4 and segment sums around the budget (0, 15, 16, 17, 31) is presented twice. The first pass uses plain latency weights and the second uses normalised weights. These passes separate the hit classes by depth and flag, and they separate avoidable from unavoidable misses at the 16/17 boundary. Very large latencies then drive the counter into both clamps, which tests saturation and the allocation flip in both directions. Idle cycles and a zero decompression latency cover the hold behaviour and the divide guard.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
    typedef enum logic [2:0] {
        CLS_NONE        = 3'd0,
        CLS_UNPEN_HIT   = 3'd1,
        CLS_PEN_HIT     = 3'd2,
        CLS_AVOIDED     = 3'd3,
        CLS_AVOIDABLE   = 3'd4,
        CLS_UNAVOIDABLE = 3'd5
    } access_cls_e;

    typedef enum logic {
        ALLOC_PACKED = 1'b0,
        ALLOC_PLAIN  = 1'b1
    } alloc_state_e;
endpackage

// File: rtl/cbp_classifier.sv
module cbp_classifier
    import cbp_pkg::*;
#(
    parameter int TAG_WAYS   = 4,
    parameter int RAW_WAYS   = 2,
    parameter int SEG_BUDGET = 16,
    parameter int DEPTH_W    = 3,
    parameter int SUM_W      = 6
) (
    input  logic               resident,
    input  logic               compressed,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [SUM_W-1:0]   seg_sum,
    output access_cls_e        cls
);
    logic tag_hit;
    logic in_raw_part;
    logic fits_budget;

    always_comb begin
        tag_hit     = (depth != '0) && (depth <= DEPTH_W'(TAG_WAYS));
        in_raw_part = (depth <= DEPTH_W'(RAW_WAYS));
        fits_budget = (seg_sum <= SUM_W'(SEG_BUDGET));
        if (!tag_hit)
            cls = CLS_UNAVOIDABLE;
        else if (resident)
            cls = in_raw_part ? (compressed ? CLS_PEN_HIT : CLS_UNPEN_HIT) : CLS_AVOIDED;
        else
            cls = fits_budget ? CLS_AVOIDABLE : CLS_UNAVOIDABLE;
    end
endmodule

// File: rtl/cbp_weight.sv
module cbp_weight
    import cbp_pkg::*;
#(
    parameter int LAT_W = 16,
    parameter int DW    = 21
) (
    input  access_cls_e             cls,
    input  logic [LAT_W-1:0]        mem_lat,
    input  logic [LAT_W-1:0]        dec_lat,
    input  logic                    norm_en,
    output logic signed [DW-1:0]    delta
);
    logic [LAT_W-1:0] ratio;
    logic [LAT_W-1:0] gain;
    logic [LAT_W-1:0] loss;

    always_comb begin
        ratio = (dec_lat == '0) ? mem_lat : (mem_lat / dec_lat);
        gain  = norm_en ? ratio : mem_lat;
        loss  = norm_en ? LAT_W'(1) : dec_lat;
        unique case (cls)
            CLS_AVOIDED,
            CLS_AVOIDABLE: delta = $signed({{(DW-LAT_W){1'b0}}, gain});
            CLS_PEN_HIT:   delta = -$signed({{(DW-LAT_W){1'b0}}, loss});
            default:       delta = '0;
        endcase
    end
endmodule

// File: rtl/cbp_sat_counter.sv
module cbp_sat_counter #(
    parameter int CNT_W = 19,
    parameter int DW    = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DW-1:0]     delta,
    output logic signed [CNT_W-1:0]  cnt,
    output logic signed [CNT_W-1:0]  cnt_next
);
    localparam logic signed [DW-1:0] HI = DW'((64'd1 << (CNT_W-1)) - 64'd1);
    localparam logic signed [DW-1:0] LO = -HI - DW'(1);

    logic signed [DW-1:0] sum;

    always_comb begin
        sum = {{(DW-CNT_W){cnt[CNT_W-1]}}, cnt} + delta;
        if (!en)
            cnt_next = cnt;
        else if (sum > HI)
            cnt_next = HI[CNT_W-1:0];
        else if (sum < LO)
            cnt_next = LO[CNT_W-1:0];
        else
            cnt_next = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_next;
    end

    // R7
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && delta > 0 && cnt == HI[CNT_W-1:0]) |=> cnt == HI[CNT_W-1:0]);
    // R7
    sat_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && delta < 0 && cnt == LO[CNT_W-1:0]) |=> cnt == LO[CNT_W-1:0]);
endmodule

// File: rtl/cbp_predictor.sv
module cbp_predictor
    import cbp_pkg::*;
#(
    parameter int TAG_WAYS   = 4,
    parameter int RAW_WAYS   = 2,
    parameter int SEG_BUDGET = 16,
    parameter int CNT_W      = 19,
    parameter int LAT_W      = 16,
    parameter int SUM_W      = 6,
    parameter int DEPTH_W    = $clog2(TAG_WAYS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_resident,
    input  logic               acc_compressed,
    input  logic [DEPTH_W-1:0] acc_depth,
    input  logic [SUM_W-1:0]   acc_seg_sum,
    input  logic [LAT_W-1:0]   mem_lat,
    input  logic [LAT_W-1:0]   dec_lat,
    input  logic               norm_en,
    output logic               cls_valid,
    output logic [2:0]         cls_code,
    output logic [CNT_W-1:0]   pred_value,
    output logic               alloc_compressed
);
    localparam int DW = CNT_W + 2;

    access_cls_e              cls_now;
    access_cls_e              cls_q;
    logic                     cls_valid_q;
    logic signed [DW-1:0]     delta;
    logic signed [CNT_W-1:0]  cnt;
    logic signed [CNT_W-1:0]  cnt_next;
    alloc_state_e             state_q;
    alloc_state_e             state_d;

    cbp_classifier #(
        .TAG_WAYS(TAG_WAYS), .RAW_WAYS(RAW_WAYS), .SEG_BUDGET(SEG_BUDGET),
        .DEPTH_W(DEPTH_W), .SUM_W(SUM_W)
    ) classify_i (
        .resident(acc_resident), .compressed(acc_compressed),
        .depth(acc_depth), .seg_sum(acc_seg_sum), .cls(cls_now)
    );

    cbp_weight #(.LAT_W(LAT_W), .DW(DW)) weight_i (
        .cls(cls_now), .mem_lat(mem_lat), .dec_lat(dec_lat),
        .norm_en(norm_en), .delta(delta)
    );

    cbp_sat_counter #(.CNT_W(CNT_W), .DW(DW)) counter_i (
        .clk(clk), .rst_n(rst_n), .en(acc_valid), .delta(delta),
        .cnt(cnt), .cnt_next(cnt_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q       <= CLS_NONE;
            cls_valid_q <= 1'b0;
        end else begin
            cls_q       <= acc_valid ? cls_now : CLS_NONE;
            cls_valid_q <= acc_valid;
        end
    end

    // allocation state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ALLOC_PACKED;
        else        state_q <= state_d;
    end

    // transitions TO_PLAIN / TO_PACKED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALLOC_PACKED: if (acc_valid && cnt_next < 0)  state_d = ALLOC_PLAIN;
            ALLOC_PLAIN:  if (acc_valid && cnt_next >= 0) state_d = ALLOC_PACKED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ALLOC_PACKED: alloc_compressed = 1'b1;
            ALLOC_PLAIN:  alloc_compressed = 1'b0;
        endcase
        cls_valid  = cls_valid_q;
        cls_code   = cls_q;
        pred_value = cnt;
    end

    // R2
    unpen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_resident && !acc_compressed && acc_depth != '0
         && acc_depth <= DEPTH_W'(RAW_WAYS)) |=> $stable(pred_value));
    // R6
    nomatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_depth == '0) |=> $stable(pred_value));
    // R3
    pen_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_resident && acc_compressed && acc_depth != '0
         && acc_depth <= DEPTH_W'(RAW_WAYS) && dec_lat != '0
         && pred_value != {1'b1, {(CNT_W-1){1'b0}}})
        |=> $signed(pred_value) < $signed($past(pred_value)));
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> cls_valid);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!cls_valid && $stable(pred_value)));
    // R8
    alloc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_compressed == !pred_value[CNT_W-1]);
endmodule

// File: tb/cbp_predictor_tb.sv
module cbp_predictor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_resident = 1'b0;
    logic        acc_compressed = 1'b0;
    logic [2:0]  acc_depth = '0;
    logic [5:0]  acc_seg_sum = '0;
    logic [15:0] mem_lat = 16'd400;
    logic [15:0] dec_lat = 16'd5;
    logic        norm_en = 1'b0;
    logic        cls_valid;
    logic [2:0]  cls_code;
    logic [18:0] pred_value;
    logic        alloc_compressed;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cbp_predictor dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .acc_resident(acc_resident), .acc_compressed(acc_compressed),
        .acc_depth(acc_depth), .acc_seg_sum(acc_seg_sum),
        .mem_lat(mem_lat), .dec_lat(dec_lat), .norm_en(norm_en),
        .cls_valid(cls_valid), .cls_code(cls_code),
        .pred_value(pred_value), .alloc_compressed(alloc_compressed)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int exp_cls(input bit res, input bit cmp, input int d, input int s);
        if (d == 0) return 5;
        if (res) return (d <= 2) ? (cmp ? 2 : 1) : 3;
        return (s <= 16) ? 4 : 5;
    endfunction

    function automatic string cls_req(input int c);
        case (c)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic access(input bit res, input bit cmp, input int d, input int s);
        int c;
        int gain;
        int loss;
        int got;
        c = exp_cls(res, cmp, d, s);
        gain = norm_en ? ((dec_lat == 0) ? int'(mem_lat) : int'(mem_lat) / int'(dec_lat)) : int'(mem_lat);
        loss = norm_en ? 1 : int'(dec_lat);
        if (c == 3 || c == 4) model = model + gain;
        if (c == 2) model = model - loss;
        if (model > 262143) model = 262143;
        if (model < -262144) model = -262144;
        @(negedge clk);
        acc_valid = 1'b1; acc_resident = res; acc_compressed = cmp;
        acc_depth = 3'(d); acc_seg_sum = 6'(s);
        @(negedge clk);
        acc_valid = 1'b0;
        got = $signed(pred_value);
        check("R10 valid", int'(cls_valid), 1);
        check(cls_req(c), int'(cls_code), c);
        check(norm_en ? "R9 counter" : (model == 262143 || model == -262144) ? "R7 counter" : cls_req(c), got, model);
        check("R8 alloc", int'(alloc_compressed), (model >= 0) ? 1 : 0);
    endtask

    task automatic sweep();
        int sums[5] = '{0, 15, 16, 17, 31};
        for (int r = 0; r < 2; r++)
            for (int cm = 0; cm < 2; cm++)
                for (int d = 0; d <= 4; d++)
                    for (int k = 0; k < 5; k++)
                        access(bit'(r), bit'(cm), d, sums[k]);
    endtask

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 counter", int'($signed(pred_value)), 0);
        check("R1 alloc", int'(alloc_compressed), 1);
        check("R1 valid", int'(cls_valid), 0);

        mem_lat = 16'd400; dec_lat = 16'd5; norm_en = 1'b0;
        sweep();
        norm_en = 1'b1;
        sweep();
        // R9 zero decompression latency guard
        dec_lat = 16'd0;
        access(1'b1, 1'b0, 3, 0);

        // R7 drive into top clamp then bottom clamp
        norm_en = 1'b0; mem_lat = 16'd65535; dec_lat = 16'd65535;
        for (int i = 0; i < 6; i++) access(1'b0, 1'b1, 2, 10);
        for (int i = 0; i < 10; i++) access(1'b1, 1'b1, 1, 0);
        // R8 flip back to packed
        for (int i = 0; i < 5; i++) access(1'b1, 1'b0, 4, 0);

        // R10 idle cycles hold state
        held = $signed(pred_value);
        repeat (4) @(negedge clk);
        check("R10 idle valid", int'(cls_valid), 0);
        check("R10 idle counter", int'($signed(pred_value)), held);

        done = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=hung expected=finish");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule